// File: doc/BRIEF.md
# Match-Triggered Watchdog Reset Timer

This block is a watchdog peripheral reached through a plain register port: a word address, a write strobe with write data, and combinational read data. An up-counter advances by one on each cycle in which the `tick` input is high. It is compared against a programmable match value. When an advancing tick finds the counter equal to the match value, a match event occurs. The event can set an interrupt flag, stop and clear the counter, drive a match output line, fire a one-cycle internal reset, and start an external reset pulse whose length is programmable. Software can also fire either reset at once through the match-control register.

A sticky status flag records that the watchdog drove a reset. It lives on a separate power-on reset, so it survives the system reset that the watchdog itself causes. Boot software can therefore read it to learn why the system restarted. A debug-halt input can freeze counting while a debugger holds the core.

Top module: `wdt_match_timer`

## Requirements
- R1: The register index is `bus_addr[4:2]`, and accesses with `bus_addr[1:0]` not zero are ignored and read zero. The indices are: 0 interrupt flag, 1 control, 2 counter, 3 match control, 4 match value, 5 match output, 6 pulse length, 7 reset status. After `rst_n` every register except reset status reads zero, and `irq`, `int_rst`, `ext_rst` and `match_out` are low.
- R2: With control bit 0 set, the counter rises by one at each clock edge where `tick` is high. With `tick` low or control bit 0 clear, it holds.
- R3: While control bit 1 is set, the counter is held at zero and reads zero.
- R4: With control bit 2 set, the counter does not advance while `dbg_halt` is high. With control bit 2 clear, `dbg_halt` has no effect.
- R5: A match sets interrupt flag bit 0 at the match edge, whatever the interrupt enable. `irq` equals that flag ANDed with match-control bit 0. Writing 1 to flag bit 0 clears it, and a match in the same cycle wins.
- R6: With match-control bit 2 set, a match clears the counter to zero and clears control bit 0.
- R7: With match-control bit 3 set, a match drives `int_rst` high for exactly one cycle, starting at the match edge. `int_rst` is never high for two cycles in a row.
- R8: With match-control bit 4 set, a match drives `ext_rst` high from the match edge for (pulse length + 2) ticks. The pulse length is in bits 15:0 of index 6. A new trigger reloads the pulse.
- R9: A write to match control with bit 5 set fires `int_rst` at that edge, whatever the counter value. A write with bit 6 set starts the `ext_rst` pulse in the same way. Bits 5 and 6 read back as zero. Bits 0, 2, 3 and 4 read back as written.
- R10: The match output register holds the `match_out` level in bit 0, which is writable, and an action in bits 5:4. On each match the action applies: 0 keeps the level, 1 drives it low, 2 drives it high, 3 toggles it.
- R11: Reset status bit 0 becomes 1 at the edge where `int_rst` or `ext_rst` is raised. It ignores writes, keeps its value through `rst_n`, and is cleared only by `por_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears the reset-status flag only |
| rst_n | input | 1 | System reset, active low; clears all other state |
| tick | input | 1 | Counter tick enable |
| dbg_halt | input | 1 | Debugger holds the core |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Match interrupt |
| int_rst | output | 1 | One-cycle internal reset request |
| ext_rst | output | 1 | External reset pulse, active high |
| match_out | output | 1 | Match output line |

## Verification
The hardest situation to reach is the exact edge where an advancing tick meets the match value while several match actions are armed at once. The bench reaches it by programming random match values, pulse lengths, action sets and output actions. Each case starts from a zero-held counter and then enables counting, so the match edge falls at a known cycle. Every cycle is then scanned for the first `irq`, the `int_rst` width and the `ext_rst` width. A second hard-to-reach case is a status flag that survives a system reset. The bench reaches it by forcing both resets, pulsing `rst_n` alone, and then pulsing `por_n`.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        RG_FLAG = 3'd0,
        RG_CTRL = 3'd1,
        RG_CNT  = 3'd2,
        RG_MCTL = 3'd3,
        RG_MVAL = 3'd4,
        RG_MOUT = 3'd5,
        RG_PLEN = 3'd6,
        RG_RSTS = 3'd7
    } reg_sel_e;

    // control bits
    localparam int B_EN  = 0;
    localparam int B_CLR = 1;
    localparam int B_DBG = 2;
    // match-control bits
    localparam int B_IE      = 0;
    localparam int B_STOP    = 2;
    localparam int B_IRST    = 3;
    localparam int B_ERST    = 4;
    localparam int B_FRC_INT = 5;
    localparam int B_FRC_EXT = 6;
    // match-output action field
    localparam int B_ACT_LO = 4;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_LOW  = 2'd1,
        ACT_HIGH = 2'd2,
        ACT_TOG  = 2'd3
    } mout_act_e;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run_en,
    input  logic             halt,
    input  logic             hold_zero,
    input  logic             stop_on_hit,
    input  logic [CNT_W-1:0] match_val,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             adv;

    always_comb begin
        adv   = run_en && tick && !halt && !hold_zero;
        hit   = adv && (cnt_q == match_val);
        cnt_d = cnt_q;
        if (hold_zero)
            cnt_d = '0;
        else if (hit && stop_on_hit)
            cnt_d = '0;
        else if (adv)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int LEN_W  = 16,
    parameter int MARGIN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             fire,
    input  logic [LEN_W-1:0] len,
    output logic             active
);
    localparam int REM_W = LEN_W + $clog2(MARGIN + 1) + 1;

    logic [REM_W-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (fire)
            rem_d = REM_W'(len) + REM_W'(MARGIN);
        else if (tick && (rem_q != '0))
            rem_d = rem_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

    assign active = (rem_q != '0);
endmodule

// File: rtl/wdt_match_timer.sv
module wdt_match_timer
    import wdt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PLEN_W = 16,
    parameter int MARGIN = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              dbg_halt,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              int_rst,
    output logic              ext_rst,
    output logic              match_out
);
    typedef struct packed {
        logic              flag;
        logic [2:0]        ctrl;
        logic              ie;
        logic              stop;
        logic              irst;
        logic              erst;
        logic [CNT_W-1:0]  mval;
        logic              mo;
        logic [1:0]        act;
        logic [PLEN_W-1:0] plen;
        logic              int_rst;
    } state_t;

    state_t           s_d, s_q;
    logic             sts_d, sts_q;
    logic [CNT_W-1:0] cnt_w;
    logic             hit_w, ext_w;
    logic             aligned, wr_ok, int_fire, ext_fire;
    reg_sel_e         sel;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign sel      = reg_sel_e'(bus_addr[ADDR_W-1:2]);
    assign wr_ok    = bus_wr && aligned;
    assign int_fire = (hit_w && s_q.irst) ||
                      (wr_ok && sel == RG_MCTL && bus_wdata[B_FRC_INT]);
    assign ext_fire = (hit_w && s_q.erst) ||
                      (wr_ok && sel == RG_MCTL && bus_wdata[B_FRC_EXT]);

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .run_en     (s_q.ctrl[B_EN]),
        .halt       (s_q.ctrl[B_DBG] && dbg_halt),
        .hold_zero  (s_q.ctrl[B_CLR]),
        .stop_on_hit(s_q.stop),
        .match_val  (s_q.mval),
        .cnt        (cnt_w),
        .hit        (hit_w)
    );

    wdt_pulse #(.LEN_W(PLEN_W), .MARGIN(MARGIN)) u_ext (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .fire  (ext_fire),
        .len   (s_q.plen),
        .active(ext_w)
    );

    always_comb begin
        s_d = s_q;
        // match effects
        if (hit_w) begin
            if (s_q.stop) s_d.ctrl[B_EN] = 1'b0;
            unique case (mout_act_e'(s_q.act))
                ACT_LOW:  s_d.mo = 1'b0;
                ACT_HIGH: s_d.mo = 1'b1;
                ACT_TOG:  s_d.mo = ~s_q.mo;
                default:  s_d.mo = s_q.mo;
            endcase
        end
        // register writes take precedence over match effects
        if (wr_ok) begin
            unique case (sel)
                RG_FLAG: if (bus_wdata[0]) s_d.flag = 1'b0;
                RG_CTRL: s_d.ctrl = bus_wdata[2:0];
                RG_MCTL: begin
                    s_d.ie   = bus_wdata[B_IE];
                    s_d.stop = bus_wdata[B_STOP];
                    s_d.irst = bus_wdata[B_IRST];
                    s_d.erst = bus_wdata[B_ERST];
                end
                RG_MVAL: s_d.mval = bus_wdata[CNT_W-1:0];
                RG_MOUT: begin
                    s_d.mo  = bus_wdata[0];
                    s_d.act = bus_wdata[B_ACT_LO +: 2];
                end
                RG_PLEN: s_d.plen = bus_wdata[PLEN_W-1:0];
                default: ;
            endcase
        end
        if (hit_w) s_d.flag = 1'b1;
        s_d.int_rst = int_fire && !s_q.int_rst;
        sts_d = sts_q | int_fire | ext_fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sts_q <= 1'b0;
        else        sts_q <= sts_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (sel)
                RG_FLAG: bus_rdata[0]   = s_q.flag;
                RG_CTRL: bus_rdata[2:0] = s_q.ctrl;
                RG_CNT:  bus_rdata[CNT_W-1:0] = cnt_w;
                RG_MCTL: begin
                    bus_rdata[B_IE]   = s_q.ie;
                    bus_rdata[B_STOP] = s_q.stop;
                    bus_rdata[B_IRST] = s_q.irst;
                    bus_rdata[B_ERST] = s_q.erst;
                end
                RG_MVAL: bus_rdata[CNT_W-1:0] = s_q.mval;
                RG_MOUT: begin
                    bus_rdata[0] = s_q.mo;
                    bus_rdata[B_ACT_LO +: 2] = s_q.act;
                end
                RG_PLEN: bus_rdata[PLEN_W-1:0] = s_q.plen;
                RG_RSTS: bus_rdata[0] = sts_q;
                default: ;
            endcase
        end
    end

    assign irq       = s_q.flag && s_q.ie;
    assign int_rst   = s_q.int_rst;
    assign ext_rst   = ext_w;
    assign match_out = s_q.mo;
endmodule

// File: rtl/wdt_match_timer_chk.sv
module wdt_match_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             por_n,
    input logic             int_rst,
    input logic             ext_rst,
    input logic             irq,
    input logic             sts,
    input logic             ie,
    input logic             dbg_en,
    input logic             dbg_halt,
    input logic             hold,
    input logic             wr,
    input logic [CNT_W-1:0] cnt
);
    // R7: internal reset lasts a single cycle
    a_r7_int_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        int_rst |=> !int_rst);

    // R11: status stays set until power-on reset
    a_r11_sts_sticky: assert property (@(posedge clk) disable iff (!por_n)
        sts |=> sts);

    // R11: an internal reset is always recorded
    a_r11_int_recorded: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        int_rst |-> sts);

    // R8: an external reset is always recorded
    a_r8_ext_recorded: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        ext_rst |-> sts);

    // R5: no interrupt without its enable
    a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ie);

    // R4: debug halt freezes the counter
    a_r4_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_en && dbg_halt && !hold && !wr) |=> $stable(cnt));
endmodule

bind wdt_match_timer wdt_match_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .por_n   (por_n),
    .int_rst (int_rst),
    .ext_rst (ext_rst),
    .irq     (irq),
    .sts     (sts_q),
    .ie      (s_q.ie),
    .dbg_en  (s_q.ctrl[2]),
    .dbg_halt(dbg_halt),
    .hold    (s_q.ctrl[1]),
    .wr      (bus_wr),
    .cnt     (cnt_w)
);

// File: tb/tb_wdt_match_timer.sv
`timescale 1ns/1ps
module tb_wdt_match_timer;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        dbg_halt = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, int_rst, ext_rst, match_out;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_sts = 1'b0;

    localparam logic [4:0] A_FLAG = 5'h00, A_CTRL = 5'h04, A_CNT = 5'h08,
                           A_MCTL = 5'h0C, A_MVAL = 5'h10, A_MOUT = 5'h14,
                           A_PLEN = 5'h18, A_RSTS = 5'h1C;

    always #5 clk = ~clk;

    wdt_match_timer dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick), .dbg_halt(dbg_halt),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .int_rst(int_rst), .ext_rst(ext_rst),
        .match_out(match_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic int exp_ext_len(input int p);
        return p + 2;
    endfunction

    function automatic logic exp_mout(input logic [1:0] act, input logic start);
        case (act)
            2'd1: return 1'b0;
            2'd2: return 1'b1;
            2'd3: return ~start;
            default: return start;
        endcase
    endfunction

    task automatic run_case(input int m, input int p, input logic [4:0] mc, input logic [1:0] act);
        int n_loop, first_irq, first_int, first_ext, n_int, n_ext;
        logic [31:0] v;
        n_loop = m + p + 8;
        first_irq = -1; first_int = -1; first_ext = -1; n_int = 0; n_ext = 0;
        wr(A_CTRL, 32'h2);
        wr(A_FLAG, 32'h1);
        wr(A_MVAL, m);
        wr(A_PLEN, p);
        wr(A_MOUT, {26'd0, act, 4'd0});
        wr(A_MCTL, {27'd0, mc});
        wr(A_CTRL, 32'h1);
        for (int i = 1; i <= n_loop; i++) begin
            @(negedge clk);
            if (irq && first_irq < 0) first_irq = i;
            if (int_rst) begin n_int++; if (first_int < 0) first_int = i; end
            if (ext_rst) begin n_ext++; if (first_ext < 0) first_ext = i; end
        end
        chk("R5 irq edge", first_irq, mc[0] ? m + 1 : -1);
        chk("R7 int_rst width", n_int, mc[3] ? 1 : 0);
        if (mc[3]) chk("R7 int_rst edge", first_int, m + 1);
        chk("R8 ext_rst width", n_ext, mc[4] ? exp_ext_len(p) : 0);
        if (mc[4]) chk("R8 ext_rst edge", first_ext, m + 1);
        rd(A_CNT, v);
        chk("R6/R2 counter after run", v, mc[2] ? 0 : n_loop);
        rd(A_CTRL, v);
        chk("R6 enable after run", v, mc[2] ? 0 : 1);
        chk("R10 match_out", match_out, exp_mout(act, 1'b0));
        rd(A_FLAG, v);
        chk("R5 flag raw", v, 1);
        exp_sts = exp_sts | mc[3] | mc[4];
        rd(A_RSTS, v);
        chk("R11 status", v, exp_sts);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int ne;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int r = 0; r < 8; r++) begin
            rd(5'(r * 4), v);
            chk("R1 reset register", v, 0);
        end
        chk("R1 outputs idle", {irq, int_rst, ext_rst, match_out}, 0);

        // R2 tick gating
        tick = 1'b0;
        wr(A_CTRL, 32'h1);
        repeat (4) @(negedge clk);
        rd(A_CNT, v);
        chk("R2 no tick holds", v, 0);
        tick = 1'b1;
        repeat (3) @(negedge clk);
        rd(A_CNT, v);
        chk("R2 counts on tick", v, 3);

        // R3 hold at zero
        wr(A_CTRL, 32'h3);
        @(negedge clk);
        rd(A_CNT, v);
        chk("R3 held zero", v, 0);
        repeat (3) @(negedge clk);
        rd(A_CNT, v);
        chk("R3 still zero", v, 0);

        // R4 debug halt
        dbg_halt = 1'b1;
        wr(A_CTRL, 32'h5);
        repeat (4) @(negedge clk);
        rd(A_CNT, v);
        chk("R4 halted", v, 0);
        wr(A_CTRL, 32'h1);
        repeat (4) @(negedge clk);
        rd(A_CNT, v);
        chk("R4 halt ignored when bit 2 clear", v, 4);
        dbg_halt = 1'b0;

        // R1 misaligned access ignored
        wr(A_MVAL | 5'h1, 32'h55);
        rd(A_MVAL, v);
        chk("R1 misaligned write ignored", v, 0);

        // R5..R10 match scenarios: directed then random
        run_case(3, 0, 5'b11101, 2'd2);
        run_case(7, 5, 5'b00001, 2'd3);
        for (int k = 0; k < 10; k++)
            run_case(1 + ($urandom % 30), $urandom % 21,
                     5'($urandom) & 5'b11101, 2'($urandom));

        // R5 write-1 clears flag
        wr(A_FLAG, 32'h1);
        rd(A_FLAG, v);
        chk("R5 flag cleared", v, 0);

        // R9 forced internal reset
        wr(A_CTRL, 32'h2);
        wr(A_MCTL, 32'h20);
        chk("R9 forced int_rst high", int_rst, 1);
        @(negedge clk);
        chk("R9 forced int_rst one cycle", int_rst, 0);
        rd(A_MCTL, v);
        chk("R9 force bits read zero", v, 0);

        // R9 forced external reset
        wr(A_PLEN, 32'd3);
        wr(A_MCTL, 32'h40);
        ne = 0;
        for (int i = 0; i < 10; i++) begin
            if (ext_rst) ne++;
            @(negedge clk);
        end
        chk("R9 forced ext_rst width", ne, exp_ext_len(3));

        // R11 status survives rst_n, cleared by por_n, ignores writes
        rd(A_RSTS, v);
        chk("R11 status set by forcing", v, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_RSTS, v);
        chk("R11 survives rst_n", v, 1);
        rd(A_PLEN, v);
        chk("R1 rst_n clears pulse length", v, 0);
        por_n = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        rd(A_RSTS, v);
        chk("R11 cleared by por_n", v, 0);
        wr(A_RSTS, 32'h1);
        rd(A_RSTS, v);
        chk("R11 write ignored", v, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule